// File: doc/BRIEF.md
# Fail-Safe Clock Supervisor with Group Switcher

This block keeps a system clock alive. A low-power reference clock, which never stops, drives the control logic. The logic watches the selected primary oscillator for edges. If the primary stops, runs too slowly, or has not started by the time the power-up timer expires, the block moves the system clock to the internal fast RC source. It then records the event in its control/status register and raises a trap request that carries the reset address as its vector.

Software can also request a switch through the register write port. Switches are allowed only between two groups: the primary group and the fast RC group. The option used inside the primary group is always taken from a configuration field. A configuration field can also lock the block. When locked, both the monitor and the switcher are off, and the configured source drives the clock directly, while the register still reports which source is active. The clock multiplexer is modelled behaviourally. It hands over glitch-free, with each clock enable changing only while its own clock is low.

Top module: `clkfail_guard`

## Requirements
- R1: On reset, `osc_reg` shows the configured source in bits 14:12 and the same code in bits 10:8, with bits 3 and 0 clear, and `trap_req` low. The source code is 3'b111 for fast RC and {0,cfg_pri_mode} for the primary group, chosen by `cfg_start_frc`.
- R2: While `cfg_sw_mon[1]` is 1, bits 14:12 follow the configured source every cycle. A write that sets bit 0 leaves bit 0 clear and does not change bits 14:12. A stopped primary never raises `trap_req`.
- R3: When unlocked, with `pwrt_done` high and a primary source active, if no primary edge is seen for TMO_CYC reference cycles, the block does three things in the same cycle: it loads bits 14:12 with 3'b111, sets bit 3 and clears bit 0.
- R4: A failure sets `trap_req`, and `trap_vec` equals RESET_VEC while `trap_req` is high (0 otherwise). A one-cycle `trap_ack` drops `trap_req` on the next edge.
- R5: Bit 3 is cleared only by a write with bit 3 = 0. Writing 1 to it never sets it.
- R6: If `pwrt_done` is high while a primary source is active and the primary has never toggled since reset, the R3 failure update happens on the next reference edge.
- R7: A write with bit 0 = 1 whose bits 10:8 name the other group moves the clock to that group. Bits 14:12 then become 3'b111, or {0,cfg_pri_mode} whatever primary option bits 10:8 carry, and bit 0 clears.
- R8: A switch request naming the group already active leaves bits 14:12 unchanged and clears bit 0 within two cycles.
- R9: `sys_clk` copies the active source. The two clock enables are never on at the same time.
- R10: A primary clock that keeps toggling within the window never raises a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Always-running low-power reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | Primary oscillator clock |
| frc_clk | input | 1 | Internal fast RC clock |
| pwrt_done | input | 1 | Power-up timer expired |
| cfg_sw_mon | input | 2 | Lock field; 1x turns off switching and monitoring |
| cfg_start_frc | input | 1 | Configured source is the fast RC group |
| cfg_pri_mode | input | 2 | Option inside the primary group |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| trap_ack | input | 1 | Trap acknowledge |
| osc_reg | output | 16 | Control/status register contents |
| trap_req | output | 1 | Clock-fail trap request |
| trap_vec | output | VEC_W | Trap vector (reset address) |
| sys_clk | output | 1 | Glitch-free selected system clock |

## Verification
The hardest state to reach is a start-up failure. The primary must be dead from reset onward, so the edge-seen flag has never been set, and the power-up timer must then expire. The bench resets with the primary clock generator held off and raises `pwrt_done` only afterwards. Later it stretches the primary half-period well beyond the window, which exercises the running timeout after a real switch back to the primary group.

// File: rtl/clkfail_pkg.sv
`timescale 1ns/1ps
package clkfail_pkg;
   localparam int OSC_W    = 16;
   localparam int SRC_W    = 3;
   localparam int CUR_LSB  = 12;
   localparam int NEW_LSB  = 8;
   localparam int CF_BIT   = 3;
   localparam int SWEN_BIT = 0;
   localparam logic [SRC_W-1:0] SRC_FRC = 3'b111;
   typedef enum logic {SW_IDLE, SW_BUSY} sw_state_e;
endpackage

// File: rtl/clkfail_sync.sv
`timescale 1ns/1ps
module clkfail_sync #(
   parameter int W       = 1,
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkfail_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or posedge clr) begin
      if (clr) stg <= {(STAGES*W){RST_VAL}};
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/clkfail_watch.sv
`timescale 1ns/1ps
module clkfail_watch #(
   parameter int TMO_CYC = 8,
   parameter int SYNC_N  = 2
) (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic pri_clk,
   input  logic arm,
   output logic fail
);
   localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

   logic             tog, tog_s, tog_d, edge_hit, seen;
   logic [CNT_W-1:0] cnt;

   // toggle flag in the primary domain
   always_ff @(posedge pri_clk or negedge rst_n) begin
      if (!rst_n) tog <= 1'b0;
      else        tog <= ~tog;
   end

   clkfail_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_tog_sync (
      .clk(ref_clk), .clr(!rst_n), .d(tog), .q(tog_s)
   );

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_d <= 1'b0;
         seen  <= 1'b0;
         cnt   <= '0;
      end else begin
         tog_d <= tog_s;
         if (edge_hit) seen <= 1'b1;
         if (!arm || edge_hit)    cnt <= '0;
         else if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
      end
   end

   assign edge_hit = tog_s ^ tog_d;
   assign fail     = arm && (!seen || (!edge_hit && cnt == CNT_LAST));
endmodule

// File: rtl/clkfail_gmux.sv
`timescale 1ns/1ps
module clkfail_gmux #(
   parameter int SYNC_N = 2
) (
   input  logic pri_clk,
   input  logic frc_clk,
   input  logic rst_n,
   input  logic want_pri,
   input  logic kill,
   output logic sys_clk,
   output logic en_pri,
   output logic en_frc
);
   logic pri_clr, frc_clr;
   logic wp_p, ef_p, wp_f, ep_f;

   assign pri_clr = !rst_n || kill;
   assign frc_clr = !rst_n;

   clkfail_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_wp_p (
      .clk(pri_clk), .clr(pri_clr), .d(want_pri), .q(wp_p));
   clkfail_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_ef_p (
      .clk(pri_clk), .clr(pri_clr), .d(en_frc), .q(ef_p));
   clkfail_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_wp_f (
      .clk(frc_clk), .clr(frc_clr), .d(want_pri), .q(wp_f));
   clkfail_sync #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_ep_f (
      .clk(frc_clk), .clr(frc_clr), .d(en_pri), .q(ep_f));

   // enables change only while their own clock is low
   always_ff @(negedge pri_clk or posedge pri_clr) begin
      if (pri_clr) en_pri <= 1'b0;
      else         en_pri <= wp_p && !ef_p;
   end

   always_ff @(negedge frc_clk or posedge frc_clr) begin
      if (frc_clr) en_frc <= 1'b0;
      else         en_frc <= !wp_f && !ep_f;
   end

   assign sys_clk = (pri_clk && en_pri) || (frc_clk && en_frc);

   always_comb begin
      if (rst_n) begin
         a_r9_onehot: assert ($onehot0({en_pri, en_frc}));
      end
   end
endmodule

// File: rtl/clkfail_guard.sv
`timescale 1ns/1ps
module clkfail_guard
   import clkfail_pkg::*;
#(
   parameter int           TMO_CYC   = 8,
   parameter int           SYNC_N    = 2,
   parameter int           VEC_W     = 16,
   parameter logic [VEC_W-1:0] RESET_VEC = 16'h0200
) (
   input  logic             ref_clk,
   input  logic             rst_n,
   input  logic             pri_clk,
   input  logic             frc_clk,
   input  logic             pwrt_done,
   input  logic [1:0]       cfg_sw_mon,
   input  logic             cfg_start_frc,
   input  logic [1:0]       cfg_pri_mode,
   input  logic             wr_en,
   input  logic [OSC_W-1:0] wr_data,
   input  logic             trap_ack,
   output logic [OSC_W-1:0] osc_reg,
   output logic             trap_req,
   output logic [VEC_W-1:0] trap_vec,
   output logic             sys_clk
);
   generate
      if (TMO_CYC < 4) begin : g_bad_tmo
         $error("TMO_CYC must cover the synchronizer latency");
      end
      if (VEC_W < 1) begin : g_bad_vec
         $error("VEC_W must be positive");
      end
   endgenerate

   logic [SRC_W-1:0] cur, nosc, pri_code, cfg_code;
   logic             cf, swen, want_pri, kill, trap_q;
   logic             sw_en, cur_on_pri, tgt_pri, tgt_done, arm, fail;
   logic             en_pri, en_frc;
   logic [1:0]       en_ref;
   sw_state_e        st;
   logic             unused_bits;

   assign sw_en      = !cfg_sw_mon[1];
   assign pri_code   = {1'b0, cfg_pri_mode};
   assign cfg_code   = cfg_start_frc ? SRC_FRC : pri_code;
   assign cur_on_pri = (cur != SRC_FRC);
   assign tgt_pri    = (nosc != SRC_FRC);
   assign tgt_done   = want_pri ? (en_ref[1] && !en_ref[0]) : (en_ref[0] && !en_ref[1]);
   assign arm        = sw_en && cur_on_pri && pwrt_done;
   assign unused_bits = ^{wr_data[15:11], wr_data[7:4], wr_data[2:1], cfg_sw_mon[0]};

   clkfail_watch #(.TMO_CYC(TMO_CYC), .SYNC_N(SYNC_N)) u_watch (
      .ref_clk(ref_clk), .rst_n(rst_n), .pri_clk(pri_clk), .arm(arm), .fail(fail));

   clkfail_gmux #(.SYNC_N(SYNC_N)) u_gmux (
      .pri_clk(pri_clk), .frc_clk(frc_clk), .rst_n(rst_n), .want_pri(want_pri),
      .kill(kill), .sys_clk(sys_clk), .en_pri(en_pri), .en_frc(en_frc));

   clkfail_sync #(.W(2), .STAGES(SYNC_N), .RST_VAL(1'b0)) u_en_ref (
      .clk(ref_clk), .clr(!rst_n), .d({en_pri, en_frc}), .q(en_ref));

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         cur      <= cfg_code;
         nosc     <= cfg_code;
         cf       <= 1'b0;
         swen     <= 1'b0;
         want_pri <= !cfg_start_frc;
         kill     <= 1'b0;
         trap_q   <= 1'b0;
         st       <= SW_IDLE;
      end else begin
         if (wr_en) nosc <= wr_data[NEW_LSB +: SRC_W];
         if (wr_en && !wr_data[CF_BIT]) cf <= 1'b0;
         if (trap_ack) trap_q <= 1'b0;
         if (!sw_en) begin
            cur      <= cfg_code;
            want_pri <= !cfg_start_frc;
            swen     <= 1'b0;
            kill     <= 1'b0;
            st       <= SW_IDLE;
         end else begin
            if (wr_en && wr_data[SWEN_BIT] && st == SW_IDLE) swen <= 1'b1;
            case (st)
               SW_IDLE: if (swen) begin
                  if (tgt_pri == cur_on_pri) swen <= 1'b0;
                  else begin
                     want_pri <= tgt_pri;
                     if (tgt_pri) kill <= 1'b0;
                     st <= SW_BUSY;
                  end
               end
               SW_BUSY: if (tgt_done) begin
                  cur  <= want_pri ? pri_code : SRC_FRC;
                  swen <= 1'b0;
                  st   <= SW_IDLE;
               end
               default: st <= SW_IDLE;
            endcase
            if (fail) begin
               cur      <= SRC_FRC;
               cf       <= 1'b1;
               swen     <= 1'b0;
               want_pri <= 1'b0;
               kill     <= 1'b1;
               trap_q   <= 1'b1;
               st       <= SW_IDLE;
            end
         end
      end
   end

   always_comb begin
      osc_reg = '0;
      osc_reg[CUR_LSB +: SRC_W] = cur;
      osc_reg[NEW_LSB +: SRC_W] = nosc;
      osc_reg[CF_BIT]           = cf;
      osc_reg[SWEN_BIT]         = swen;
   end

   assign trap_req = trap_q;
   assign trap_vec = trap_q ? RESET_VEC : '0;

   a_r3_fail_update: assert property (@(posedge ref_clk) disable iff (!rst_n)
      fail |=> (cur == SRC_FRC && cf && !swen && trap_q));
   a_r4_ack_drop: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (trap_q && trap_ack && !fail) |=> !trap_q);
   a_r5_cf_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cf && !(wr_en && !wr_data[CF_BIT])) |=> cf);
   a_r2_locked: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (cfg_sw_mon[1] && !trap_q) |=> (!trap_q && !swen));
   a_r8_same_group: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (sw_en && st == SW_IDLE && swen && tgt_pri == cur_on_pri && !fail && !wr_en)
      |=> (!swen && $stable(cur)));
endmodule

// File: tb/sim_clkfail_guard.sv
`timescale 1ns/1ps
module sim_clkfail_guard;
   logic        ref_clk = 1'b0;
   logic        pri_clk = 1'b0;
   logic        frc_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwrt_done = 1'b0;
   logic [1:0]  cfg_sw_mon = 2'b10;
   logic        cfg_start_frc = 1'b0;
   logic [1:0]  cfg_pri_mode = 2'b01;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        trap_ack = 1'b0;
   logic [15:0] osc_reg;
   logic        trap_req;
   logic [15:0] trap_vec;
   logic        sys_clk;
   logic        pri_run = 1'b1;
   real         pri_half = 3.5;
   int          checks = 0;
   int          errors = 0;

   // {lock[1:0], start_frc, pri_mode[1:0], expected current code[2:0]}
   localparam logic [7:0] VEC [6] = '{
      8'b10_0_00_000, 8'b11_0_01_001, 8'b10_1_01_111,
      8'b11_0_10_010, 8'b10_1_00_111, 8'b10_0_11_011 };

   clkfail_guard u0 (
      .ref_clk(ref_clk), .rst_n(rst_n), .pri_clk(pri_clk), .frc_clk(frc_clk),
      .pwrt_done(pwrt_done), .cfg_sw_mon(cfg_sw_mon), .cfg_start_frc(cfg_start_frc),
      .cfg_pri_mode(cfg_pri_mode), .wr_en(wr_en), .wr_data(wr_data),
      .trap_ack(trap_ack), .osc_reg(osc_reg), .trap_req(trap_req),
      .trap_vec(trap_vec), .sys_clk(sys_clk));

   always #2.5 ref_clk = ~ref_clk;
   always #1.5 frc_clk = ~frc_clk;
   always begin
      if (pri_run) #(pri_half) pri_clk = ~pri_clk;
      else begin pri_clk = 1'b0; #1; end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] d);
      wr_en = 1'b1; wr_data = d;
      tick(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic follow(input string req, input bit use_pri);
      for (int i = 0; i < 4; i++) begin
         if (use_pri) @(posedge pri_clk); else @(posedge frc_clk);
         #0.5 chk(req, {31'd0, sys_clk}, 32'd1);
         if (use_pri) @(negedge pri_clk); else @(negedge frc_clk);
         #0.5 chk(req, {31'd0, sys_clk}, 32'd0);
      end
      tick(1);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #1000000;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 reg", {16'd0, osc_reg}, 32'h1100);
      chk("R1 trap", {31'd0, trap_req}, 32'd0);
      // R2 locked mode table
      foreach (VEC[i]) begin
         cfg_sw_mon = VEC[i][7:6]; cfg_start_frc = VEC[i][5]; cfg_pri_mode = VEC[i][4:3];
         tick(3);
         chk("R2 cur", {29'd0, osc_reg[14:12]}, {29'd0, VEC[i][2:0]});
         chk("R2 trap", {31'd0, trap_req}, 32'd0);
      end
      wr(16'h0701);
      tick(2);
      chk("R2 swen ignored", {16'd0, osc_reg}, 32'h3700);
      pri_run = 1'b0; pwrt_done = 1'b1;
      tick(40);
      chk("R2 no monitor", {31'd0, trap_req}, 32'd0);
      chk("R2 reg kept", {16'd0, osc_reg}, 32'h3700);

      // R6 start-up failure
      rst_n = 1'b0; pwrt_done = 1'b0;
      cfg_sw_mon = 2'b00; cfg_start_frc = 1'b0; cfg_pri_mode = 2'b10;
      tick(2);
      rst_n = 1'b1;
      chk("R1 reg enabled", {16'd0, osc_reg}, 32'h2200);
      tick(5);
      chk("R6 quiet before timer", {31'd0, trap_req}, 32'd0);
      pwrt_done = 1'b1;
      tick(1);
      chk("R6 fail update", {16'd0, osc_reg}, 32'h7208);
      chk("R4 trap raised", {31'd0, trap_req}, 32'd1);
      chk("R4 vector", {16'd0, trap_vec}, 32'h0200);
      trap_ack = 1'b1; tick(1); trap_ack = 1'b0;
      chk("R4 ack drop", {31'd0, trap_req}, 32'd0);
      chk("R4 vector idle", {16'd0, trap_vec}, 32'h0);
      chk("R5 cf held", {31'd0, osc_reg[3]}, 32'd1);
      wr(16'h0708);
      chk("R5 write one", {31'd0, osc_reg[3]}, 32'd1);
      wr(16'h0700);
      chk("R5 write zero", {31'd0, osc_reg[3]}, 32'd0);
      tick(10);
      follow("R9 frc", 1'b0);

      // R7 back to the primary group, option from config
      pri_half = 3.5; pri_run = 1'b1;
      tick(5);
      wr(16'h0001);
      tick(30);
      chk("R7 to primary", {16'd0, osc_reg}, 32'h2000);
      follow("R9 pri", 1'b1);
      tick(60);
      chk("R10 no fail", {31'd0, trap_req}, 32'd0);
      chk("R10 cf clear", {31'd0, osc_reg[3]}, 32'd0);
      // R8 same group
      wr(16'h0101);
      tick(2);
      chk("R8 same group", {16'd0, osc_reg}, 32'h2100);
      // R7 to fast RC
      wr(16'h0701);
      tick(30);
      chk("R7 to frc", {16'd0, osc_reg}, 32'h7700);
      chk("R7 no trap", {31'd0, trap_req}, 32'd0);
      wr(16'h0001);
      tick(30);
      chk("R7 back", {16'd0, osc_reg}, 32'h2000);
      // R3 slow primary
      pri_half = 40.0;
      tick(40);
      chk("R3 slow fail", {16'd0, osc_reg}, 32'h7008);
      chk("R3 trap", {31'd0, trap_req}, 32'd1);
      summary();
   end
endmodule